// File: doc/BRIEF.md
# Warm Reset Sequencer

This block orders a warm reset of a processor subsystem. A warm reset request from software, from the external reset pin or from the programmable-logic region starts a sequence. First the block works through up to five optional request/acknowledge handshakes, one agent at a time. The agents are the memory controller (enter self-refresh), the configuration manager, the scan manager, the programmable-logic region, and the trace unit (finish outstanding bus transactions and go idle). Each handshake has its own enable bit and its own timeout. A timeout is recorded but does not stop the sequence, so the reset always completes.

After the handshakes, the block asserts the clock-manager reset and the system warm reset together. It also pulls the external reset pin low for a programmable number of cycles. After a fixed hold time it releases the clock-manager reset. It releases the system warm reset a programmable delay later. The delay is clamped to the legal range of 17 to 255 cycles.

A 32-bit sticky status word records which source requested the reset and which handshakes timed out. Software clears it by writing a mask.

Top module: `warm_rst_seq`

## Requirements
- R1: After `rstN` is released, every `hsReq` bit is 0, `clkMgrRst` and `warmRst` are 0, `extRstN` is 1 and `status` is 0.
- R2: A high cycle on `swWarmReq`, `pinWarmReq` or `plWarmReq` while the block is idle starts a sequence. The request also sets status bit 10, bit 8 or bit 9 respectively.
- R3: Handshakes run one at a time, for the stages whose `hsEnable` bit is set. The order is fixed, and each stage uses the same index in `hsEnable`, `hsReq` and `hsAck`: 0 = self-refresh, 1 = configuration manager, 2 = scan manager, 3 = programmable logic, 4 = trace-unit stall. Disabled stages are skipped, and at most one `hsReq` bit is high at a time.
- R4: A request stays high until its acknowledge is sampled high. If the acknowledge arrives L cycles after the request rose (1 ≤ L ≤ HS_TIMEOUT), the request is high for exactly L cycles, and no timeout is recorded.
- R5: A request with no acknowledge is high for exactly HS_TIMEOUT cycles. The timeout sets status bit 24 + stage index, and the sequence then moves on to the next stage.
- R6: No warm reset output is asserted while any handshake request is high.
- R7: `clkMgrRst` and `warmRst` rise in the same cycle. `clkMgrRst` stays high for RST_HOLD cycles, and `warmRst` stays high for RST_HOLD plus the release delay.
- R8: A `releaseDelay` below 17 is used as 17, a value above 255 is used as 255, and any other value is used unchanged.
- R9: `extRstN` goes low in the cycle the resets rise and stays low for `pinCycles` cycles. A value of 0 leaves it high.
- R10: A cycle with `clrEn` high clears exactly the status bits that are set in `clrMask`.
- R11: When a status bit is set and cleared in the same cycle, it ends up set.
- R12: A request that arrives while a sequence is in progress sets its status bit but does not start a second sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| swWarmReq | input | 1 | Software warm reset request |
| pinWarmReq | input | 1 | Warm reset request from the external pin |
| plWarmReq | input | 1 | Warm reset request from the programmable-logic region |
| hsEnable | input | 5 | Per-stage handshake enable |
| hsAck | input | 5 | Per-stage acknowledge from the agents |
| hsReq | output | 5 | Per-stage request to the agents |
| releaseDelay | input | DLY_W | Cycles from clock-manager release to system release |
| pinCycles | input | PIN_W | External pin low time in cycles |
| clkMgrRst | output | 1 | Clock-manager reset, active high |
| warmRst | output | 1 | System warm reset, active high |
| extRstN | output | 1 | External reset pin, active low |
| clrEn | input | 1 | Status clear strobe |
| clrMask | input | 32 | Status bits to clear |
| status | output | 32 | Sticky reset-cause and timeout bits |

## Verification
A wrong stage index or a skipped stage shows up on the `hsReq` lines in the first cycle of the faulty stage. It appears as a request on the wrong line or out of order. A miscounted timeout, hold time, release delay or pin counter changes the width of a pulse that the bench measures at the ports. It also sets or misses a status bit, which is read once the sequence ends. Errors in the status logic show on `status` one cycle after the set or clear cycle.

// File: rtl/wrs_pkg.sv
package wrs_pkg;
  localparam int NUM_HS   = 5;
  localparam int STAT_W   = 32;
  localparam int BIT_PIN  = 8;
  localparam int BIT_PL   = 9;
  localparam int BIT_SW   = 10;
  localparam int BIT_TMO0 = 24;
  localparam int DLY_MIN  = 17;
  localparam int DLY_MAX  = 255;

  typedef enum logic [1:0] {S_IDLE, S_HS, S_HOLD, S_REL} seqState_t;

  typedef struct packed {
    logic              cntClr;
    logic              loadSeq;
    logic [NUM_HS-1:0] tmoSet;
  } seqStrobe_t;
endpackage

// File: rtl/wrs_ctrl.sv
module wrs_ctrl
  import wrs_pkg::*;
#(
  parameter int HS_TIMEOUT = 64,
  parameter int CNT_W      = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [NUM_HS-1:0] hsEn,
  input  logic [NUM_HS-1:0] hsAck,
  input  logic              tmoHit,
  input  logic              holdDone,
  input  logic              dlyDone,
  input  logic [CNT_W-1:0]  stageCnt,
  output seqStrobe_t        strobe,
  output logic [NUM_HS-1:0] hsReq,
  output logic              clkRst,
  output logic              sysRst
);
  seqState_t  state, nState;
  logic [2:0] idx, nIdx;
  logic [3:0] pickFirst, pickNext;
  logic       ackCur;

  // returns {found, index} of the lowest enabled stage at or above 'from'
  function automatic logic [3:0] pickStage(input logic [NUM_HS-1:0] en, input int from);
    logic [3:0] r;
    r = 4'b0;
    for (int i = NUM_HS - 1; i >= 0; i--)
      if (en[i] && i >= from) r = {1'b1, 3'(i)};
    return r;
  endfunction

  for (genvar g = 0; g < NUM_HS; g++) begin : g_req
    assign hsReq[g] = (state == S_HS) && (idx == 3'(g));
  end

  assign ackCur    = |(hsAck & hsReq);
  assign pickFirst = pickStage(hsEn, 0);
  assign pickNext  = pickStage(hsEn, int'(idx) + 1);
  assign clkRst    = (state == S_HOLD);
  assign sysRst    = (state == S_HOLD) || (state == S_REL);

  always_comb begin
    nState = state;
    nIdx   = idx;
    case (state)
      S_IDLE: if (startReq) begin
        if (pickFirst[3]) begin
          nState = S_HS;
          nIdx   = pickFirst[2:0];
        end else begin
          nState = S_HOLD;
        end
      end
      S_HS: if (ackCur || tmoHit) begin
        if (pickNext[3]) nIdx = pickNext[2:0];
        else             nState = S_HOLD;
      end
      S_HOLD: if (holdDone) nState = S_REL;
      S_REL:  if (dlyDone)  nState = S_IDLE;
      default: nState = S_IDLE;
    endcase
  end

  always_comb begin
    strobe.cntClr  = (nState != state) || (nIdx != idx);
    strobe.loadSeq = (nState == S_HOLD) && (state != S_HOLD);
    strobe.tmoSet  = (state == S_HS && tmoHit && !ackCur) ? hsReq : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      idx   <= 3'd0;
    end else begin
      state <= nState;
      idx   <= nIdx;
    end
  end

  // R3
  one_req_chk: assert property (@(posedge clk) disable iff (!rstN) $onehot0(hsReq));
  // R5
  tmo_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_HS) |-> (stageCnt < CNT_W'(HS_TIMEOUT)));
  // R6
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hsReq != '0) |-> !sysRst);
  // R7
  joint_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sysRst) |-> clkRst);
endmodule

// File: rtl/wrs_dp.sv
module wrs_dp
  import wrs_pkg::*;
#(
  parameter int HS_TIMEOUT = 64,
  parameter int RST_HOLD   = 8,
  parameter int DLY_W      = 9,
  parameter int PIN_W      = 20,
  parameter int CNT_W      = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic              swReq,
  input  logic              pinReq,
  input  logic              plReq,
  input  logic              clrEn,
  input  logic [STAT_W-1:0] clrMask,
  input  logic [DLY_W-1:0]  releaseDelay,
  input  logic [PIN_W-1:0]  pinCycles,
  output logic [CNT_W-1:0]  stageCnt,
  output logic              tmoHit,
  output logic              holdDone,
  output logic              dlyDone,
  output logic              extRstN,
  output logic [STAT_W-1:0] status
);
  logic [7:0]        dlyClamped, dlyLat;
  logic [CNT_W-1:0]  dlyLast;
  logic [PIN_W-1:0]  pinCnt;
  logic [STAT_W-1:0] setVec, clrVec;

  always_comb begin
    if (releaseDelay < DLY_W'(DLY_MIN))      dlyClamped = 8'(DLY_MIN);
    else if (releaseDelay > DLY_W'(DLY_MAX)) dlyClamped = 8'(DLY_MAX);
    else                                     dlyClamped = 8'(releaseDelay);
  end

  assign dlyLast  = CNT_W'(dlyLat - 8'd1);
  assign tmoHit   = (stageCnt == CNT_W'(HS_TIMEOUT - 1));
  assign holdDone = (stageCnt == CNT_W'(RST_HOLD - 1));
  assign dlyDone  = (stageCnt == dlyLast);
  assign extRstN  = (pinCnt == '0);

  always_comb begin
    setVec         = '0;
    setVec[BIT_SW]  = swReq;
    setVec[BIT_PIN] = pinReq;
    setVec[BIT_PL]  = plReq;
    for (int i = 0; i < NUM_HS; i++) setVec[BIT_TMO0 + i] = strobe.tmoSet[i];
    clrVec = clrEn ? clrMask : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageCnt <= '0;
      dlyLat   <= 8'(DLY_MIN);
      pinCnt   <= '0;
      status   <= '0;
    end else begin
      stageCnt <= strobe.cntClr ? '0 : stageCnt + 1'b1;
      status   <= (status & ~clrVec) | setVec;
      if (strobe.loadSeq) begin
        dlyLat <= dlyClamped;
        pinCnt <= pinCycles;
      end else if (pinCnt != '0) begin
        pinCnt <= pinCnt - 1'b1;
      end
    end
  end

  // R8
  dly_range_chk: assert property (@(posedge clk) disable iff (!rstN) dlyLat >= 8'(DLY_MIN));
  // R9
  pin_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadSeq && pinCycles == '0) |=> extRstN);
  // R11
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|setVec) |=> ((status & $past(setVec)) == $past(setVec)));
  // R10
  clear_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clrEn && setVec == '0) |=> (status == ($past(status) & ~$past(clrMask))));
endmodule

// File: rtl/warm_rst_seq.sv
module warm_rst_seq
  import wrs_pkg::*;
#(
  parameter int HS_TIMEOUT = 64,
  parameter int RST_HOLD   = 8,
  parameter int DLY_W      = 9,
  parameter int PIN_W      = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              swWarmReq,
  input  logic              pinWarmReq,
  input  logic              plWarmReq,
  input  logic [4:0]        hsEnable,
  input  logic [4:0]        hsAck,
  output logic [4:0]        hsReq,
  input  logic [DLY_W-1:0]  releaseDelay,
  input  logic [PIN_W-1:0]  pinCycles,
  output logic              clkMgrRst,
  output logic              warmRst,
  output logic              extRstN,
  input  logic              clrEn,
  input  logic [31:0]       clrMask,
  output logic [31:0]       status
);
  localparam int CNT_M1  = (HS_TIMEOUT > RST_HOLD) ? HS_TIMEOUT : RST_HOLD;
  localparam int CNT_MAX = (CNT_M1 > DLY_MAX + 1) ? CNT_M1 : DLY_MAX + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  seqStrobe_t       strobe;
  logic [CNT_W-1:0] stageCnt;
  logic             tmoHit, holdDone, dlyDone;

  wrs_ctrl #(.HS_TIMEOUT(HS_TIMEOUT), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .startReq(swWarmReq | pinWarmReq | plWarmReq),
    .hsEn(hsEnable), .hsAck(hsAck),
    .tmoHit(tmoHit), .holdDone(holdDone), .dlyDone(dlyDone), .stageCnt(stageCnt),
    .strobe(strobe), .hsReq(hsReq), .clkRst(clkMgrRst), .sysRst(warmRst)
  );

  wrs_dp #(.HS_TIMEOUT(HS_TIMEOUT), .RST_HOLD(RST_HOLD), .DLY_W(DLY_W),
           .PIN_W(PIN_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .swReq(swWarmReq), .pinReq(pinWarmReq), .plReq(plWarmReq),
    .clrEn(clrEn), .clrMask(clrMask),
    .releaseDelay(releaseDelay), .pinCycles(pinCycles),
    .stageCnt(stageCnt), .tmoHit(tmoHit), .holdDone(holdDone), .dlyDone(dlyDone),
    .extRstN(extRstN), .status(status)
  );
endmodule

// File: tb/sim_warm_rst_seq.sv
`timescale 1ns/1ps
module sim_warm_rst_seq;
  localparam int T    = 20;
  localparam int HOLD = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rstN, swWarmReq, pinWarmReq, plWarmReq, clrEn;
  logic [4:0]  hsEnable, hsAck, hsReq;
  logic [8:0]  releaseDelay;
  logic [19:0] pinCycles;
  logic [31:0] clrMask, status;
  logic        clkMgrRst, warmRst, extRstN;

  int checks = 0;
  int errors = 0;

  warm_rst_seq #(.HS_TIMEOUT(T), .RST_HOLD(HOLD), .DLY_W(9), .PIN_W(20)) u0 (
    .clk(clk), .rstN(rstN), .swWarmReq(swWarmReq), .pinWarmReq(pinWarmReq),
    .plWarmReq(plWarmReq), .hsEnable(hsEnable), .hsAck(hsAck), .hsReq(hsReq),
    .releaseDelay(releaseDelay), .pinCycles(pinCycles), .clkMgrRst(clkMgrRst),
    .warmRst(warmRst), .extRstN(extRstN), .clrEn(clrEn), .clrMask(clrMask),
    .status(status)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clearBits(input logic [31:0] m);
    @(negedge clk); clrEn = 1'b1; clrMask = m;
    @(negedge clk); clrEn = 1'b0; clrMask = '0;
  endtask

  task automatic waitDone();
    int n = 0;
    while (!warmRst && n < 2000) begin @(negedge clk); n++; end
    while ((warmRst || !extRstN) && n < 4000) begin @(negedge clk); n++; end
    chk("R7 sequence ends", n < 4000, 1);
  endtask

  // src: 0 software, 1 pin, 2 programmable logic
  task automatic runSeq(input int src, input logic [4:0] en, input logic [4:0][7:0] lat,
                        input int dly, input int pin);
    int reqCnt[5];
    int order[5];
    int nOrd = 0, cyc = 0, clkCnt = 0, sysCnt = 0, pinCnt = 0;
    int clkStart = -1, pinStart = -1, dExp, k;
    bit multi = 0, overlap = 0, sawSys = 0, done = 0;
    logic [31:0] sExp;
    for (int i = 0; i < 5; i++) begin reqCnt[i] = 0; order[i] = -1; end
    hsEnable = en; releaseDelay = 9'(dly); pinCycles = 20'(pin);
    @(negedge clk);
    if (src == 0) swWarmReq = 1'b1; else if (src == 1) pinWarmReq = 1'b1; else plWarmReq = 1'b1;
    while (!done) begin
      @(negedge clk);
      cyc++;
      swWarmReq = 1'b0; pinWarmReq = 1'b0; plWarmReq = 1'b0;
      for (int i = 0; i < 5; i++) begin
        if (hsReq[i]) begin
          if (reqCnt[i] == 0) begin
            if (nOrd < 5) order[nOrd] = i;
            nOrd++;
          end
          reqCnt[i]++;
          hsAck[i] = (lat[i] != 0) && (reqCnt[i] >= int'(lat[i]));
        end else hsAck[i] = 1'b0;
      end
      if ($countones(hsReq) > 1) multi = 1;
      if (hsReq != '0 && (warmRst || clkMgrRst)) overlap = 1;
      if (clkMgrRst) begin if (clkStart < 0) clkStart = cyc; clkCnt++; end
      if (warmRst) begin sawSys = 1; sysCnt++; end
      if (!extRstN) begin if (pinStart < 0) pinStart = cyc; pinCnt++; end
      if ((sawSys && !warmRst && extRstN) || cyc > 4000) done = 1;
    end
    hsAck = '0;
    chk("R7 sequence completes", cyc <= 4000, 1);
    k = 0;
    sExp = 32'd1 << (src == 0 ? 10 : (src == 1 ? 8 : 9));
    for (int i = 0; i < 5; i++) begin
      if (en[i]) begin
        chk("R3 stage order", order[k], i);
        k++;
        if (lat[i] == 0 || int'(lat[i]) > T) begin
          chk("R5 timeout request width", reqCnt[i], T);
          sExp[24 + i] = 1'b1;
        end else chk("R4 ack request width", reqCnt[i], lat[i]);
      end
    end
    chk("R3 stage count", nOrd, k);
    chk("R3 single request", multi, 0);
    chk("R6 no reset during handshake", overlap, 0);
    dExp = dly < 17 ? 17 : (dly > 255 ? 255 : dly);
    chk("R7 clock reset width", clkCnt, HOLD);
    chk("R8 system reset width", sysCnt, HOLD + dExp);
    chk("R9 pin low width", pinCnt, pin);
    if (pin > 0) chk("R9 pin starts with resets", pinStart, clkStart);
    chk("R2 R5 status", status, sExp);
    clearBits('1);
    chk("R10 full clear", status, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R7 actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [4:0][7:0] lat;
    int n;
    rstN = 1'b0; swWarmReq = 0; pinWarmReq = 0; plWarmReq = 0; clrEn = 0;
    hsEnable = '0; hsAck = '0; releaseDelay = 9'd17; pinCycles = '0; clrMask = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 reset requests", hsReq, 0);
    chk("R1 reset outputs", {clkMgrRst, warmRst, extRstN}, 3'b001);
    chk("R1 reset status", status, 0);

    for (int e = 0; e < 32; e++) begin
      for (int i = 0; i < 5; i++)
        lat[i] = ((e + i) % 4 == 0) ? 8'd0 : 8'(i + 1 + e % 3);
      runSeq(0, 5'(e), lat, e * 9, (e % 4 == 0) ? 0 : e * 3 + 1);
    end
    lat = '0;
    runSeq(1, 5'b00000, lat, 17, 1);
    for (int i = 0; i < 5; i++) lat[i] = 8'(T);
    runSeq(2, 5'b11111, lat, 255, 0);
    lat = '0;
    runSeq(0, 5'b10101, lat, 16, 2);
    runSeq(0, 5'b01010, lat, 300, 0);

    // R12: request during a running sequence
    hsEnable = '0; releaseDelay = 9'd60; pinCycles = '0;
    @(negedge clk); swWarmReq = 1'b1;
    @(negedge clk); swWarmReq = 1'b0;
    repeat (4) @(negedge clk);
    plWarmReq = 1'b1;
    @(negedge clk); plWarmReq = 1'b0;
    waitDone();
    n = 0;
    for (int c = 0; c < 40; c++) begin @(negedge clk); if (clkMgrRst || warmRst) n++; end
    chk("R12 no second sequence", n, 0);
    chk("R12 busy request recorded", status, (32'd1 << 10) | (32'd1 << 9));
    // R10: partial clear
    clearBits(32'd1 << 9);
    chk("R10 partial clear", status, 32'd1 << 10);
    // R11: set and clear in same cycle
    @(negedge clk); clrEn = 1'b1; clrMask = '1; swWarmReq = 1'b1;
    @(negedge clk); clrEn = 1'b0; clrMask = '0; swWarmReq = 1'b0;
    chk("R11 set wins", status, 32'd1 << 10);
    waitDone();
    clearBits('1);
    chk("R10 clear after set-wins", status, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule